// File: doc/BRIEF.md
# Register Alias Rename Table

This block keeps, for every architectural register of an out-of-order core, a record of whether the register's newest value is still being produced by an in-flight instruction. If it is, the record also gives which reorder-buffer slot will hold that value. Each cycle, two source lookups return a valid flag and a slot index per operand. A valid result tells the consumer to take the operand from the named reorder-buffer slot. An invalid result tells it to read the committed register file.

In the same cycle a rename write points one destination register at the reorder-buffer slot newly allocated at the tail. A commit port retires one slot. Its mapping is dropped only when the table still names that slot as the register's producer, so a younger redefinition stays in place. A flush input, used on a mispredict or fault, invalidates the whole table in one step.

The lookups read the table as it stood before this cycle's update. An instruction that reads and overwrites the same register therefore sees its older producer.

Top module: `rat_table`

## Requirements
- R1: After synchronous reset every register maps as invalid; a lookup returns valid 0 and slot index 0.
- R2: A lookup of a register with a valid mapping returns valid 1 and the stored slot index; a lookup of an invalid register returns valid 0 and slot index 0 (meaning: read the committed register file).
- R3: When ren_valid is 1 and flush is 0 at a clock edge, the register ren_dst maps, from the next cycle on, to slot ren_tag with valid 1, replacing any older mapping.
- R4: Lookups are combinational from the table state before the current cycle's update, so a lookup of ren_dst in the same cycle as the rename returns the previous mapping.
- R5: When cm_valid is 1 and register cm_reg is valid with a stored slot equal to cm_tag, the mapping becomes invalid at that edge.
- R6: A commit whose cm_tag differs from the stored slot, or that targets an invalid register, leaves the mapping unchanged.
- R7: If a rename write and a matching commit clear target the same register at one edge, the register takes the new rename mapping.
- R8: flush at an edge invalidates every register and overrides any rename write or commit in that cycle.
- R9: With ren_valid and cm_valid both 0 and flush 0, the table keeps every mapping, whatever the values on ren_dst, ren_tag, cm_reg and cm_tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every mapping |
| ren_valid | input | 1 | Rename destination write enable |
| ren_dst | input | IDX_W | Destination architectural register |
| ren_tag | input | TAG_W | Reorder-buffer slot given to the destination |
| src0_reg | input | IDX_W | First source register to look up |
| src0_valid | output | 1 | First source is in flight |
| src0_tag | output | TAG_W | Slot producing first source (0 if not in flight) |
| src1_reg | input | IDX_W | Second source register to look up |
| src1_valid | output | 1 | Second source is in flight |
| src1_tag | output | TAG_W | Slot producing second source (0 if not in flight) |
| cm_valid | input | 1 | Commit port active |
| cm_reg | input | IDX_W | Destination register of the retiring slot |
| cm_tag | input | TAG_W | Index of the retiring slot |

## Verification
The bench builds the table with its defaults of 16 architectural registers and 32 reorder-buffer slots. With 16 registers it can fill the whole table and check every entry after a flush. The 5-bit slot index is wide enough to pick tags that share low bits with the stored slot but still mismatch. This exercises the stale-commit and same-cycle rename-versus-commit cases against a fully populated table.

// File: rtl/rat_pkg.sv
package rat_pkg;

    localparam int DEF_ARCH_REGS = 16;
    localparam int DEF_ROB_SLOTS = 32;

    // Next-state choice for one table entry.
    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_CLEAR = 2'd1,
        UPD_MAP   = 2'd2
    } upd_e;

    function automatic int idx_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Flush outranks the rename write, which outranks a commit clear.
    function automatic upd_e pick_update(input logic flush_i,
                                         input logic wr_hit_i,
                                         input logic cm_match_i);
        if (flush_i)         return UPD_CLEAR;
        else if (wr_hit_i)   return UPD_MAP;
        else if (cm_match_i) return UPD_CLEAR;
        else                 return UPD_HOLD;
    endfunction

endpackage

// File: rtl/rat_decoder.sv
module rat_decoder #(
    parameter int N     = rat_pkg::DEF_ARCH_REGS,
    parameter int IDX_W = rat_pkg::idx_bits(N)
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [N-1:0]     hit
);
    always_comb begin
        for (int i = 0; i < N; i++) begin
            hit[i] = en && (idx == IDX_W'(i));
        end
    end
endmodule

// File: rtl/rat_entry.sv
module rat_entry
    import rat_pkg::*;
#(
    parameter int TAG_W = idx_bits(DEF_ROB_SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_hit,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             cm_hit,
    input  logic [TAG_W-1:0] cm_tag,
    output logic             map_valid,
    output logic [TAG_W-1:0] map_tag
);
    logic cm_match;
    upd_e action;

    assign cm_match = cm_hit && map_valid && (map_tag == cm_tag);
    assign action   = pick_update(flush, wr_hit, cm_match);

    always_ff @(posedge clk) begin
        if (rst) begin
            map_valid <= 1'b0;
            map_tag   <= '0;
        end else begin
            unique case (action)
                UPD_MAP: begin
                    map_valid <= 1'b1;
                    map_tag   <= wr_tag;
                end
                UPD_CLEAR: begin
                    map_valid <= 1'b0;
                    map_tag   <= '0;
                end
                default: ;
            endcase
        end
    end

    p_flush_clears_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> !map_valid);

    p_rename_maps_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !flush) |=> (map_valid && map_tag == $past(wr_tag)));

    p_commit_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (cm_hit && map_valid && map_tag == cm_tag && !wr_hit && !flush) |=> !map_valid);

    p_stale_commit_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (cm_hit && map_tag != cm_tag && !wr_hit && !flush)
            |=> ($stable(map_valid) && $stable(map_tag)));

    p_rename_beats_commit_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && cm_hit && !flush) |=> map_valid);

endmodule

// File: rtl/rat_read_port.sv
module rat_read_port #(
    parameter int N     = rat_pkg::DEF_ARCH_REGS,
    parameter int TAG_W = rat_pkg::idx_bits(rat_pkg::DEF_ROB_SLOTS),
    parameter int IDX_W = rat_pkg::idx_bits(N)
) (
    input  logic [N-1:0]       valid_vec,
    input  logic [N*TAG_W-1:0] tag_flat,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_valid,
    output logic [TAG_W-1:0]   rd_tag
);
    always_comb begin
        rd_valid = 1'b0;
        rd_tag   = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_idx == IDX_W'(i) && valid_vec[i]) begin
                rd_valid = 1'b1;
                rd_tag   = tag_flat[i*TAG_W +: TAG_W];
            end
        end
    end
endmodule

// File: rtl/rat_table.sv
module rat_table
    import rat_pkg::*;
#(
    parameter int NUM_ARCH_REGS = DEF_ARCH_REGS,
    parameter int ROB_SLOTS     = DEF_ROB_SLOTS,
    parameter int IDX_W         = idx_bits(NUM_ARCH_REGS),
    parameter int TAG_W         = idx_bits(ROB_SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             ren_valid,
    input  logic [IDX_W-1:0] ren_dst,
    input  logic [TAG_W-1:0] ren_tag,
    input  logic [IDX_W-1:0] src0_reg,
    output logic             src0_valid,
    output logic [TAG_W-1:0] src0_tag,
    input  logic [IDX_W-1:0] src1_reg,
    output logic             src1_valid,
    output logic [TAG_W-1:0] src1_tag,
    input  logic             cm_valid,
    input  logic [IDX_W-1:0] cm_reg,
    input  logic [TAG_W-1:0] cm_tag
);
    localparam int N_SRC = 2;

    logic [NUM_ARCH_REGS-1:0]       wr_hit;
    logic [NUM_ARCH_REGS-1:0]       cm_hit;
    logic [NUM_ARCH_REGS-1:0]       valid_vec;
    logic [NUM_ARCH_REGS*TAG_W-1:0] tag_flat;

    logic [IDX_W-1:0] src_reg   [N_SRC];
    logic             src_valid [N_SRC];
    logic [TAG_W-1:0] src_tag   [N_SRC];

    rat_decoder #(.N(NUM_ARCH_REGS), .IDX_W(IDX_W)) u_wr_dec (
        .en(ren_valid), .idx(ren_dst), .hit(wr_hit));

    rat_decoder #(.N(NUM_ARCH_REGS), .IDX_W(IDX_W)) u_cm_dec (
        .en(cm_valid), .idx(cm_reg), .hit(cm_hit));

    for (genvar g = 0; g < NUM_ARCH_REGS; g++) begin : g_entry
        rat_entry #(.TAG_W(TAG_W)) u_entry (
            .clk       (clk),
            .rst       (rst),
            .flush     (flush),
            .wr_hit    (wr_hit[g]),
            .wr_tag    (ren_tag),
            .cm_hit    (cm_hit[g]),
            .cm_tag    (cm_tag),
            .map_valid (valid_vec[g]),
            .map_tag   (tag_flat[g*TAG_W +: TAG_W])
        );
    end

    assign src_reg[0] = src0_reg;
    assign src_reg[1] = src1_reg;

    for (genvar p = 0; p < N_SRC; p++) begin : g_port
        rat_read_port #(.N(NUM_ARCH_REGS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_port (
            .valid_vec (valid_vec),
            .tag_flat  (tag_flat),
            .rd_idx    (src_reg[p]),
            .rd_valid  (src_valid[p]),
            .rd_tag    (src_tag[p])
        );
    end

    assign src0_valid = src_valid[0];
    assign src0_tag   = src_tag[0];
    assign src1_valid = src_valid[1];
    assign src1_tag   = src_tag[1];

    p_flush_all_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));

    p_idle_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (!flush && !ren_valid && !cm_valid) |=> $stable(valid_vec) && $stable(tag_flat));

endmodule

// File: tb/rat_table_tb_top.sv
`timescale 1ns/1ps
module rat_table_tb_top;
    localparam int NR    = 16;
    localparam int NS    = 32;
    localparam int IDX_W = 4;
    localparam int TAG_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0, ren_valid = 1'b0, cm_valid = 1'b0;
    logic [IDX_W-1:0] ren_dst = '0, src0_reg = '0, src1_reg = '0, cm_reg = '0;
    logic [TAG_W-1:0] ren_tag = '0, cm_tag = '0;
    logic             src0_valid, src1_valid;
    logic [TAG_W-1:0] src0_tag, src1_tag;

    always #4 clk = ~clk;

    rat_table #(.NUM_ARCH_REGS(NR), .ROB_SLOTS(NS)) dut_i (
        .clk(clk), .rst(rst), .flush(flush),
        .ren_valid(ren_valid), .ren_dst(ren_dst), .ren_tag(ren_tag),
        .src0_reg(src0_reg), .src0_valid(src0_valid), .src0_tag(src0_tag),
        .src1_reg(src1_reg), .src1_valid(src1_valid), .src1_tag(src1_tag),
        .cm_valid(cm_valid), .cm_reg(cm_reg), .cm_tag(cm_tag));

    typedef struct {
        bit    v0;
        int    t0;
        bit    v1;
        int    t1;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    bit m_v [NR];
    int m_t [NR];

    // Monitor: compares lookups 2 ns after the driving edge.
    always begin
        @(negedge clk);
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (src0_valid !== e.v0 || int'(src0_tag) != e.t0 ||
                src1_valid !== e.v1 || int'(src1_tag) != e.t1) begin
                errors++;
                $display("FAIL %s: got v0=%0d t0=%0d v1=%0d t1=%0d, expected v0=%0d t0=%0d v1=%0d t1=%0d",
                         e.req, src0_valid, src0_tag, src1_valid, src1_tag,
                         e.v0, e.t0, e.v1, e.t1);
            end
        end
    end

    // Driver: drive a cycle, queue expected lookups from the model, update the model.
    task automatic step(input string req, input int s0, input int s1,
                        input bit rv, input int rd, input int rt,
                        input bit cv, input int cr, input int ct, input bit fl,
                        input bit chk);
        exp_t e;
        @(negedge clk);
        src0_reg = IDX_W'(s0); src1_reg = IDX_W'(s1);
        ren_valid = rv; ren_dst = IDX_W'(rd); ren_tag = TAG_W'(rt);
        cm_valid = cv;  cm_reg = IDX_W'(cr);  cm_tag = TAG_W'(ct);
        flush = fl;
        if (chk) begin
            e.v0 = m_v[s0]; e.t0 = m_v[s0] ? m_t[s0] : 0;
            e.v1 = m_v[s1]; e.t1 = m_v[s1] ? m_t[s1] : 0;
            e.req = req;
            exp_q.push_back(e);
        end
        @(posedge clk);
        #1;
        if (fl) begin
            for (int i = 0; i < NR; i++) begin m_v[i] = 1'b0; m_t[i] = 0; end
        end else begin
            if (cv && m_v[cr] && m_t[cr] == ct) begin m_v[cr] = 1'b0; m_t[cr] = 0; end
            if (rv) begin m_v[rd] = 1'b1; m_t[rd] = rt; end
        end
    endtask

    task automatic look(input string req, input int s0, input int s1);
        step(req, s0, s1, 0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        for (int i = 0; i < NR; i++) begin m_v[i] = 1'b0; m_t[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        look("R1 reset", 0, 15);
        look("R1 reset", 6, 7);

        // R4: same-cycle lookup sees the old (invalid) mapping
        step("R4 read-before-write", 6, 6, 1, 6, 5, 0, 0, 0, 0, 1);
        look("R3 R2 mapped", 6, 7);
        step("R4 old producer", 6, 0, 1, 6, 9, 0, 0, 0, 0, 1);
        look("R3 redefined", 6, 6);

        // R6: stale commit of slot 5 and commit to an invalid register
        step("R6 stale commit", 6, 6, 0, 0, 0, 1, 6, 5, 0, 1);
        step("R6 commit invalid reg", 6, 2, 0, 0, 0, 1, 2, 0, 0, 1);
        look("R6 kept", 6, 2);
        step("R6 near-miss tag", 6, 6, 0, 0, 0, 1, 6, 8, 0, 1);
        look("R6 kept", 6, 6);

        // R5: matching commit clears
        step("R5 commit", 6, 6, 0, 0, 0, 1, 6, 9, 0, 1);
        look("R5 cleared", 6, 6);

        // R7: rename and matching commit on same register
        step("R3 map r3", 3, 3, 1, 3, 2, 0, 0, 0, 0, 1);
        step("R7 collide", 3, 6, 1, 3, 7, 1, 3, 2, 0, 1);
        look("R7 rename wins", 3, 3);

        // R9: idle cycle with stray field values
        step("R9 idle", 3, 4, 0, 3, 31, 0, 3, 7, 0, 1);
        look("R9 unchanged", 3, 4);

        // fill the whole table
        for (int i = 0; i < NR; i++) step("R3 fill", i, 0, 1, i, (i * 3 + 1) % NS, 0, 0, 0, 0, 0);
        for (int i = 0; i < NR; i += 2) look("R2 R3 filled", i, i + 1);

        // R8: flush with a concurrent rename and commit
        step("R8 flush", 4, 5, 1, 4, 20, 1, 5, 16, 1, 1);
        for (int i = 0; i < NR; i += 2) look("R8 flushed", i, i + 1);

        step("R3 after flush", 0, 0, 1, 12, 30, 0, 0, 0, 0, 1);
        look("R3 after flush", 12, 13);

        repeat (3) @(posedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL R2: %0d lookups not compared, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1: watchdog expired, got hang, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule